// File: doc/BRIEF.md
# Carry-In Add/Subtract Execution Unit

This block executes one class of integer instructions: add with carry and subtract with carry, each available at 64-bit or 32-bit width and each with an optional flag update. A 32-bit instruction word arrives with a valid strobe. The block decodes the word and drives the two source register indices combinationally, so that an external register file can return the operand values in the same cycle. One cycle later it presents the destination index, the result, a write-enable and an illegal-encoding indication.

A four-bit condition flag register lives inside the block and is held in the order N, Z, C, V from bit 3 down to bit 0. Its carry bit is the carry-in to every operation. Subtraction is formed as the first operand plus the bitwise inverse of the second operand plus the carry, so a set carry means "no borrow". At 32-bit width only the low halves of the operands are used, the flags are taken at bit 31/32, and the result is zero-extended to 64 bits.

Top module: `adcx_unit`

## Requirements
- R1: The instruction fields are decoded as follows: bit 31 selects the width (1 = 64-bit), bit 30 selects subtract (1) or add (0), bit 29 enables the flag update, bits 20:16 index the second source, bits 15:10 form a reserved sub-opcode, bits 9:5 index the first source, and bits 4:0 index the destination. The source indices are driven combinationally. An accepted instruction gives out_valid = 1 with its destination index on the next clock edge.
- R2: If the reserved sub-opcode is nonzero, out_illegal = 1, out_wen = 0, out_data = 0, and the flag register keeps its value.
- R3: With op = 0, the result is src_a + src_b + C, where C is the current carry flag. A flag change made by an instruction is seen as the carry-in by the instruction that follows it directly.
- R4: With op = 1, the result is src_a + NOT src_b + C.
- R5: With width = 0, only bits 31:0 of each operand are used, and the 32-bit result is zero-extended to 64 bits on out_data.
- R6: With the flag-enable bit = 0, the result is written (out_wen = 1) and the flag register keeps its value.
- R7: With the flag-enable bit = 1, C (flags_q[1]) is the carry out of the active width: bit 64 of the three-input sum, or bit 32 at 32-bit width.
- R8: With the flag-enable bit = 1, N (flags_q[3]) is the top bit of the active-width result, and Z (flags_q[2]) is set when the active-width result is zero.
- R9: With the flag-enable bit = 1, V (flags_q[0]) is the top active-width bit of (result XOR src_a) AND NOT (src_a XOR y), where y is the possibly inverted second operand.
- R10: A synchronous active-high reset clears the flag register to 0000 and clears out_valid.
- R11: When in_valid = 0, out_valid is 0 on the next edge and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are valid |
| in_insn | input | 32 | Instruction word |
| src_a_idx | output | 5 | First source register index (combinational) |
| src_b_idx | output | 5 | Second source register index (combinational) |
| in_src_a | input | 64 | First operand value |
| in_src_b | input | 64 | Second operand value |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_rd | output | 5 | Destination register index |
| out_wen | output | 1 | Destination write-enable |
| out_illegal | output | 1 | Unallocated encoding |
| out_data | output | 64 | Result value |
| flags_q | output | 4 | Flag register {N,Z,C,V} |

## Verification
The bench uses a carry-in of 0 and of 1. It places sums exactly on the 32-bit and 64-bit carry boundaries and checks that a carry out of the low half does not count in 64-bit mode and that upper bits do not leak in 32-bit mode. A design that took the carry from the wrong bit, or that forgot the zero-extension, would produce the wrong C or stray upper bits. Signed overflow is checked in the positive and the negative direction. This catches a design that uses the un-inverted operand in the overflow formula. Subtract with src_a equal to src_b is run with and without a borrow: a design that added one unconditionally in place of the carry would return zero in both cases. Nonzero reserved sub-opcodes are checked to confirm that they suppress both writeback and flag update. A back-to-back pair is checked to confirm that a flag update is forwarded to the next instruction's carry-in.

// File: rtl/adcx_pkg.sv
package adcx_pkg;

  localparam int INSN_W = 32;
  localparam int IDX_W  = 5;
  localparam int SUBOP_W = 6;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef struct packed {
    logic             wide;
    logic             sub;
    logic             setf;
    logic             bad;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] sa;
    logic [IDX_W-1:0] sb;
  } adcx_dec_t;

endpackage

// File: rtl/adcx_decode.sv
module adcx_decode
  import adcx_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output adcx_dec_t         dec
);
  localparam int WIDE_BIT = 31;
  localparam int SUB_BIT  = 30;
  localparam int SETF_BIT = 29;
  localparam int SB_LSB   = 16;
  localparam int SUB_LSB  = 10;
  localparam int SA_LSB   = 5;
  localparam int DST_LSB  = 0;

  always_comb begin
    dec.wide = insn[WIDE_BIT];
    dec.sub  = insn[SUB_BIT];
    dec.setf = insn[SETF_BIT];
    dec.bad  = |insn[SUB_LSB +: SUBOP_W];
    dec.dst  = insn[DST_LSB +: IDX_W];
    dec.sa   = insn[SA_LSB +: IDX_W];
    dec.sb   = insn[SB_LSB +: IDX_W];
  end
endmodule

// File: rtl/adcx_lane.sv
module adcx_lane #(
  parameter int W = 64
) (
  input  logic         cin,
  input  logic [W-1:0] a,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         neg,
  output logic         zero,
  output logic         ovf
);
  logic [W:0] wide_sum;
  logic [W-1:0] ovf_vec;

  always_comb begin
    wide_sum = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, cin};
    sum      = wide_sum[W-1:0];
    cout     = wide_sum[W];
    neg      = wide_sum[W-1];
    zero     = (wide_sum[W-1:0] == '0);
    ovf_vec  = (wide_sum[W-1:0] ^ a) & ~(a ^ y);
    ovf      = ovf_vec[W-1];
  end
endmodule

// File: rtl/adcx_exec.sv
module adcx_exec
  import adcx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            wide,
  input  logic            sub,
  input  logic            cin,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output nzcv_t           flags
);
  localparam int HLEN = XLEN / 2;
  localparam int NLANE = 2;

  logic [XLEN-1:0] y;
  logic [NLANE-1:0] l_cout, l_neg, l_zero, l_ovf;
  logic [XLEN-1:0] full_sum;
  logic [HLEN-1:0] half_sum;

  assign y = sub ? ~b : b;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = (g == 0) ? XLEN : HLEN;
    logic [LW-1:0] s;
    adcx_lane #(.W(LW)) u_lane (
      .cin  (cin),
      .a    (a[LW-1:0]),
      .y    (y[LW-1:0]),
      .sum  (s),
      .cout (l_cout[g]),
      .neg  (l_neg[g]),
      .zero (l_zero[g]),
      .ovf  (l_ovf[g])
    );
    if (g == 0) begin : g_full
      assign full_sum = s;
    end else begin : g_half
      assign half_sum = s;
    end
  end

  always_comb begin
    if (wide) begin
      res     = full_sum;
      flags.n = l_neg[0];
      flags.z = l_zero[0];
      flags.c = l_cout[0];
      flags.v = l_ovf[0];
    end else begin
      res     = {{(XLEN-HLEN){1'b0}}, half_sum};
      flags.n = l_neg[1];
      flags.z = l_zero[1];
      flags.c = l_cout[1];
      flags.v = l_ovf[1];
    end
  end
endmodule

// File: rtl/adcx_unit.sv
module adcx_unit
  import adcx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       in_insn,
  output logic [4:0]        src_a_idx,
  output logic [4:0]        src_b_idx,
  input  logic [XLEN-1:0]   in_src_a,
  input  logic [XLEN-1:0]   in_src_b,
  output logic              out_valid,
  output logic [4:0]        out_rd,
  output logic              out_wen,
  output logic              out_illegal,
  output logic [XLEN-1:0]   out_data,
  output logic [3:0]        flags_q
);
  adcx_dec_t       dec;
  nzcv_t           flag_r;
  nzcv_t           new_flags;
  logic [XLEN-1:0] res;

  adcx_decode u_dec (
    .insn (in_insn),
    .dec  (dec)
  );

  assign src_a_idx = dec.sa;
  assign src_b_idx = dec.sb;

  adcx_exec #(.XLEN(XLEN)) u_exec (
    .wide  (dec.wide),
    .sub   (dec.sub),
    .cin   (flag_r.c),
    .a     (in_src_a),
    .b     (in_src_b),
    .res   (res),
    .flags (new_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_r      <= '0;
      out_valid   <= 1'b0;
      out_rd      <= '0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
      out_data    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_rd      <= dec.dst;
        out_illegal <= dec.bad;
        out_wen     <= !dec.bad;
        out_data    <= dec.bad ? '0 : res;
        if (dec.setf && !dec.bad) begin
          flag_r <= new_flags;
        end
      end else begin
        out_wen     <= 1'b0;
        out_illegal <= 1'b0;
      end
    end
  end

  assign flags_q = flag_r;
endmodule

// File: rtl/adcx_unit_chk.sv
module adcx_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [31:0]     in_insn,
  input logic            out_valid,
  input logic [4:0]      out_rd,
  input logic            out_wen,
  input logic            out_illegal,
  input logic [XLEN-1:0] out_data,
  input logic [3:0]      flags_q
);
  localparam int HLEN = XLEN / 2;

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && flags_q == 4'b0000));

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid && out_rd == $past(in_insn[4:0])));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && flags_q == $past(flags_q)));

  a_r2_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> !out_wen);

  a_r2_illegal_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_insn[15:10] != 6'd0) |=> (out_illegal && flags_q == $past(flags_q)));

  a_r6_noset_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_insn[29]) |=> flags_q == $past(flags_q));

  a_r5_zero_extend: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_insn[31]) |=> out_data[XLEN-1:HLEN] == '0);

  a_r8_nz_wide: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_insn[31] && in_insn[29] && in_insn[15:10] == 6'd0)
      |=> (flags_q[3] == out_data[XLEN-1] && flags_q[2] == (out_data == '0)));
endmodule

bind adcx_unit adcx_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_insn     (in_insn),
  .out_valid   (out_valid),
  .out_rd      (out_rd),
  .out_wen     (out_wen),
  .out_illegal (out_illegal),
  .out_data    (out_data),
  .flags_q     (flags_q)
);

// File: tb/test_adcx_unit.sv
`timescale 1ns/1ps
module test_adcx_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic [4:0]  src_a_idx, src_b_idx;
  logic [63:0] in_src_a = '0;
  logic [63:0] in_src_b = '0;
  logic        out_valid, out_wen, out_illegal;
  logic [4:0]  out_rd;
  logic [63:0] out_data;
  logic [3:0]  flags_q;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adcx_unit i_adcx_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .in_src_a(in_src_a), .in_src_b(in_src_b),
    .out_valid(out_valid), .out_rd(out_rd), .out_wen(out_wen),
    .out_illegal(out_illegal), .out_data(out_data), .flags_q(flags_q)
  );

  typedef struct packed {
    logic        sf;
    logic        op;
    logic        s;
    logic [5:0]  sub;
    logic        cin;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp_d;
    logic        exp_ill;
    logic [3:0]  exp_f;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,6'd0,1'b0,64'd5,64'd7,64'd12,1'b0,4'b0000},                       // R3 R6 cin0
    '{1'b1,1'b0,1'b0,6'd0,1'b1,64'd5,64'd7,64'd13,1'b0,4'b0110},                       // R3 R6 cin1
    '{1'b1,1'b0,1'b1,6'd0,1'b1,64'hFFFF_FFFF_FFFF_FFFF,64'd0,64'd0,1'b0,4'b0110},       // R7 R8
    '{1'b0,1'b0,1'b1,6'd0,1'b1,64'h1234_5678_FFFF_FFFF,64'hABCD_0000_0000_0000,64'd0,1'b0,4'b0110}, // R5 R7
    '{1'b0,1'b0,1'b1,6'd0,1'b0,64'h0000_0001_7FFF_FFFF,64'hFFFF_0000_0000_0001,64'h0000_0000_8000_0000,1'b0,4'b1001}, // R9 R5
    '{1'b1,1'b0,1'b1,6'd0,1'b0,64'h7FFF_FFFF_FFFF_FFFF,64'd1,64'h8000_0000_0000_0000,1'b0,4'b1001}, // R9 pos
    '{1'b1,1'b0,1'b1,6'd0,1'b0,64'h8000_0000_0000_0000,64'h8000_0000_0000_0000,64'd0,1'b0,4'b0111}, // R9 neg
    '{1'b1,1'b1,1'b1,6'd0,1'b1,64'h1234,64'h1234,64'd0,1'b0,4'b0110},                  // R4 no borrow
    '{1'b1,1'b1,1'b1,6'd0,1'b0,64'h1234,64'h1234,64'hFFFF_FFFF_FFFF_FFFF,1'b0,4'b1000}, // R4 borrow
    '{1'b0,1'b1,1'b1,6'd0,1'b0,64'hDEAD_0000_0000_0005,64'h0000_BEEF_0000_0005,64'h0000_0000_FFFF_FFFF,1'b0,4'b1000}, // R4 R5
    '{1'b1,1'b1,1'b0,6'd0,1'b1,64'd10,64'd3,64'd7,1'b0,4'b0110},                       // R4 R6
    '{1'b0,1'b0,1'b1,6'd0,1'b0,64'hFFFF_FFFF_0000_0001,64'h0000_0001_0000_0002,64'd3,1'b0,4'b0000}, // R5 R7
    '{1'b0,1'b0,1'b1,6'd0,1'b0,64'h0000_0000_8000_0000,64'h0000_0000_8000_0000,64'd0,1'b0,4'b0111}, // R9 R7 32
    '{1'b1,1'b0,1'b1,6'd1,1'b1,64'd1,64'd1,64'd0,1'b1,4'b0110},                        // R2
    '{1'b0,1'b1,1'b1,6'h20,1'b0,64'd1,64'd1,64'd0,1'b1,4'b0000},                       // R2
    '{1'b1,1'b1,1'b1,6'd0,1'b1,64'h7FFF_FFFF_FFFF_FFFF,64'hFFFF_FFFF_FFFF_FFFF,64'h8000_0000_0000_0000,1'b0,4'b1001} // R9 R4
  };

  function automatic logic [31:0] mk(logic sf, logic op, logic s, logic [5:0] sub,
                                     logic [4:0] bi, logic [4:0] ai, logic [4:0] di);
    return {sf, op, s, 8'b1101_0000, bi, sub, ai, di};
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic issue(logic [31:0] insn, logic [63:0] a, logic [63:0] b);
    in_insn = insn; in_src_a = a; in_src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog: actual timeout expected completion");
    n_checks++; n_fail++;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [3:0] hold;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    do_reset();
    // R10 reset state
    check("R10 reset", {123'd0, out_valid, flags_q}, {123'd0, 1'b0, 4'b0000});

    // R1 source index decode (combinational)
    in_insn = mk(1'b1, 1'b0, 1'b0, 6'd0, 5'd17, 5'd9, 5'd3);
    #1;
    check("R1 idx", {118'd0, src_a_idx, src_b_idx}, {118'd0, 5'd9, 5'd17});

    for (int i = 0; i < NV; i++) begin
      do_reset();
      if (VECS[i].cin) begin
        @(negedge clk);
        issue(mk(1'b1, 1'b0, 1'b1, 6'd0, 5'd1, 5'd2, 5'd0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
      end else begin
        @(negedge clk);
      end
      issue(mk(VECS[i].sf, VECS[i].op, VECS[i].s, VECS[i].sub, 5'd4, 5'd5, 5'(i)),
            VECS[i].a, VECS[i].b);
      check($sformatf("R1 R2 ctl vec%0d", i),
            {120'd0, out_valid, out_illegal, out_wen, out_rd},
            {120'd0, 1'b1, VECS[i].exp_ill, !VECS[i].exp_ill, 5'(i)});
      check($sformatf("R3 R4 R5 data vec%0d", i), {64'd0, out_data}, {64'd0, VECS[i].exp_d});
      check($sformatf("R6 R7 R8 R9 flags vec%0d", i), {124'd0, flags_q}, {124'd0, VECS[i].exp_f});
    end

    // R3 back-to-back carry forwarding
    do_reset();
    @(negedge clk);
    in_insn = mk(1'b1, 1'b0, 1'b1, 6'd0, 5'd1, 5'd2, 5'd6);
    in_src_a = 64'hFFFF_FFFF_FFFF_FFFF; in_src_b = 64'd1; in_valid = 1'b1;
    @(negedge clk);
    in_insn = mk(1'b1, 1'b0, 1'b0, 6'd0, 5'd1, 5'd2, 5'd7);
    in_src_a = 64'd0; in_src_b = 64'd0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 fwd carry", {59'd0, out_rd, out_data}, {59'd0, 5'd7, 64'd1});

    // R11 idle: outputs drop, flags hold
    hold = flags_q;
    @(negedge clk);
    check("R11 idle", {123'd0, out_valid, flags_q}, {123'd0, 1'b0, hold});
    check("R11 no wen", {126'd0, out_wen, out_illegal}, {128'd0});

    // R10 reset after activity clears flags
    do_reset();
    check("R10 reset flags", {124'd0, flags_q}, {128'd0});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule